// File: doc/BRIEF.md
# Video Dot-Clock Divider

This block turns an external video clock into a dot-rate enable for a print engine's video path. The video clock is not used as a clock. It is sampled by the synchronous system clock, and each qualifying transition becomes a one-cycle edge event. A prescaler divides the events by 1, 2, 3 or 4. A fixed eight-step phase stage follows it and emits one single-cycle dot enable per completed period.

An edge-mode bit picks what counts as an event. In rising-only mode only low-to-high transitions count. In both-edge mode every transition counts, which halves the ratio measured in video-clock periods. The prescale code and edge mode are captured into a shadow register every cycle. The running configuration is reloaded from that shadow only by a soft-reset strobe, so software can change the settings between pages without disturbing a page in flight.

When the source select chooses the bypass path, the dot enable follows a bypass input and the divider counters hold their values.

Top module: `vdc_dot_divider`

## Requirements
- R1: With the edge mode 0 (rising-only) and prescale code c (0..3), the prescale factor is f = c+1, and exactly one dot enable is produced per 8*f rising edges of the video clock. That is one per 8*f video periods.
- R2: With the edge mode 1 (both edges), rising and falling transitions each count as one event, and exactly one dot enable is produced per 8*f events. That is one per 4*f video periods.
- R3: After a soft reset, the first dot enable comes on exactly the 8*f-th edge event. No pulse comes on any earlier event.
- R4: Each dot enable on the divider path lasts one system clock cycle.
- R5: A change to the prescale code or edge mode without a soft reset leaves the running ratio unchanged. The shadowed values, held for at least one cycle, become the running configuration at the next soft reset.
- R6: A soft reset clears both divider counters, so events counted before it do not count toward the next pulse. The dot enable is low on the divider path in the soft-reset cycle.
- R7: While the source select src_pll is 0, dot_en equals bypass_en in the same cycle and edge events are not counted. Counting resumes from the held state when src_pll returns to 1.
- R8: The active flag is 1 only while src_pll is 1 and a soft reset has been seen since hard reset. It is 0 in bypass.
- R9: After hard reset, and before the first soft reset, the divider produces no dot enable for any number of video edges and the active flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than twice the video clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| vclk_in | input | 1 | External video clock, sampled as data |
| prescale_code | input | 2 | Prescale factor minus one (shadowed) |
| edge_both | input | 1 | 0: rising edges only, 1: both edges (shadowed) |
| src_pll | input | 1 | 1: divider path, 0: bypass path |
| bypass_en | input | 1 | Dot enable passed through on the bypass path |
| soft_rst | input | 1 | One-cycle strobe: clears counters and loads the shadow |
| dot_en | output | 1 | Dot-rate enable, one cycle per dot |
| active | output | 1 | Divider armed and selected |

## Verification
The bench sweeps all eight prescale and edge-mode pairs. For each pair it counts video edges up to one short of the period, expects silence, and then expects the pulse on the very next edge. A divider whose terminal count is off by one, or that fires early after reset, fails there. It then checks the cycle spacing between pulses, which separates a design that halves the ratio in both-edge mode from one that ignores falling edges.

Further cases cover settings changed without a soft reset (a design that applies them at once would shift the ratio), a soft reset in mid-period (stale counts would bring the pulse early), and bypass with edges arriving (unfrozen counters would bring the pulse early on resume). The bench also checks that no divider pulse lasts two cycles.

// File: rtl/vdc_pkg.sv
package vdc_pkg;
   // Width of the prescale code; factor = code + 1
   localparam int unsigned CODE_W = 2;

   typedef struct packed {
      logic [CODE_W-1:0] code;
      logic              both;
   } vdc_cfg_t;

   localparam vdc_cfg_t CFG_RESET = '{code: '0, both: 1'b0};
endpackage

// File: rtl/vdc_edge_sense.sv
// Samples the asynchronous video clock and produces one-cycle edge events.
module vdc_edge_sense #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vclk_in,
   input  logic both_edges,
   output logic edge_evt
);
   localparam int unsigned TOP = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("vdc_edge_sense: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], vclk_in};
         prev_q <= sync_q[TOP];
      end
   end

   assign rise     = sync_q[TOP] & ~prev_q;
   assign fall     = ~sync_q[TOP] & prev_q;
   assign edge_evt = rise | (both_edges & fall);
endmodule

// File: rtl/vdc_mod_counter.sv
// Modulo counter: counts 0..limit on step, wraps with a one-cycle flag.
module vdc_mod_counter #(
   parameter int unsigned WIDTH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [WIDTH-1:0] limit,
   output logic [WIDTH-1:0] count,
   output logic             wrap
);
   if (WIDTH < 1) begin : g_bad_width
      $error("vdc_mod_counter: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] count_q;
   logic             at_limit;

   assign at_limit = (count_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_q <= '0;
      else if (clear)
         count_q <= '0;
      else if (step)
         count_q <= at_limit ? '0 : count_q + 1'b1;
   end

   assign count = count_q;
   assign wrap  = step & ~clear & at_limit;
endmodule

// File: rtl/vdc_cfg_stage.sv
// Shadow register for the divider settings; applied only on load.
module vdc_cfg_stage
   import vdc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  vdc_cfg_t new_cfg,
   input  logic     load,
   output vdc_cfg_t live_cfg
);
   vdc_cfg_t pending_q, live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q <= CFG_RESET;
         live_q    <= CFG_RESET;
      end else begin
         pending_q <= new_cfg;
         if (load)
            live_q <= pending_q;
      end
   end

   assign live_cfg = live_q;
endmodule

// File: rtl/vdc_dot_divider.sv
module vdc_dot_divider
   import vdc_pkg::*;
#(
   parameter int unsigned PHASE_STEPS = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vclk_in,
   input  logic [CODE_W-1:0] prescale_code,
   input  logic              edge_both,
   input  logic              src_pll,
   input  logic              bypass_en,
   input  logic              soft_rst,
   output logic              dot_en,
   output logic              active
);
   localparam int unsigned PH_W = (PHASE_STEPS > 1) ? $clog2(PHASE_STEPS) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASE_STEPS - 1);

   if (PHASE_STEPS < 2) begin : g_bad_phase
      $error("vdc_dot_divider: PHASE_STEPS must be at least 2");
   end

   vdc_cfg_t          new_cfg, live_cfg;
   logic [CODE_W-1:0] live_code;
   logic              live_both;
   logic              armed_q, run, edge_evt;
   logic [CODE_W-1:0] pre_cnt;
   logic [PH_W-1:0]   ph_cnt;
   logic              pre_wrap, ph_wrap, pulse_q;

   assign new_cfg = '{code: prescale_code, both: edge_both};

   vdc_cfg_stage u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .new_cfg  (new_cfg),
      .load     (soft_rst),
      .live_cfg (live_cfg)
   );

   assign live_code = live_cfg.code;
   assign live_both = live_cfg.both;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        armed_q <= 1'b0;
      else if (soft_rst) armed_q <= 1'b1;
   end

   assign run = armed_q & src_pll & ~soft_rst;

   vdc_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk        (clk),
      .rst_n      (rst_n),
      .vclk_in    (vclk_in),
      .both_edges (live_both),
      .edge_evt   (edge_evt)
   );

   vdc_mod_counter #(.WIDTH(CODE_W)) u_prescale (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (soft_rst),
      .step  (run & edge_evt),
      .limit (live_code),
      .count (pre_cnt),
      .wrap  (pre_wrap)
   );

   vdc_mod_counter #(.WIDTH(PH_W)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (soft_rst),
      .step  (pre_wrap),
      .limit (PH_LAST),
      .count (ph_cnt),
      .wrap  (ph_wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pulse_q <= 1'b0;
      else if (soft_rst) pulse_q <= 1'b0;
      else               pulse_q <= ph_wrap;
   end

   assign dot_en = src_pll ? (pulse_q & ~soft_rst) : bypass_en;
   assign active = armed_q & src_pll;
endmodule

// File: rtl/vdc_dot_divider_checker.sv
module vdc_dot_divider_checker
   import vdc_pkg::*;
#(
   parameter int unsigned PH_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst,
   input logic              src_pll,
   input logic              dot_en,
   input logic              active,
   input logic [CODE_W-1:0] pre_cnt,
   input logic [PH_W-1:0]   ph_cnt,
   input logic [CODE_W-1:0] live_code,
   input logic              live_both
);
   // R1: the prescale count never passes the running code
   a_r1_prescale_range: assert property (@(posedge clk) disable iff (!rst_n)
      pre_cnt <= live_code);

   // R4: divider pulses are one cycle wide
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (src_pll && dot_en) |=> !(src_pll && dot_en));

   // R5: the running settings move only on soft reset
   a_r5_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_rst |=> $stable({live_code, live_both}));

   // R6: quiet output and cleared counters around soft reset
   a_r6_quiet_in_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && src_pll) |-> !dot_en);
   a_r6_counters_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (pre_cnt == '0 && ph_cnt == '0));

   // R7: counters frozen in bypass
   a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_pll && !soft_rst) |=> ($stable(pre_cnt) && $stable(ph_cnt)));

   // R8: active only on the divider path, and set by soft reset
   a_r8_active_needs_pll: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> src_pll);
   a_r8_active_after_soft: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && src_pll) |=> (active || !src_pll));
endmodule

bind vdc_dot_divider vdc_dot_divider_checker #(.PH_W(PH_W)) u_chk (.*);

// File: tb/vdc_dot_divider_test.sv
`timescale 1ns/1ps
module vdc_dot_divider_test;
   localparam int H = 2;          // system cycles per video half-period
   localparam int LIMIT = 200000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vclk_in = 1'b0;
   logic [1:0] prescale_code = 2'd0;
   logic       edge_both = 1'b0;
   logic       src_pll = 1'b1;
   logic       bypass_en = 1'b0;
   logic       soft_rst = 1'b0;
   logic       dot_en, active;

   int checks = 0, fails = 0;
   int cyc = 0, pulses = 0, t_prev = 0, t_last = 0, dbl = 0;
   logic last_div_pulse = 1'b0;

   vdc_dot_divider uut (.*);

   always #2 clk = ~clk;
   always @(posedge clk) cyc++;

   always @(negedge clk) begin
      if (dot_en) begin
         pulses++;
         t_prev = t_last;
         t_last = cyc;
      end
      if (dot_en && src_pll && last_div_pulse) dbl++;
      last_div_pulse = dot_en && src_pll;
   end

   task automatic check(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic events(input int n, input bit both);
      for (int i = 0; i < n; i++) begin
         if (both) begin
            vclk_in = ~vclk_in; step(H);
         end else begin
            vclk_in = 1'b1; step(H);
            vclk_in = 1'b0; step(H);
         end
      end
      step(6);
   endtask

   task automatic do_soft_reset();
      soft_rst = 1'b1; step(1);
      soft_rst = 1'b0; step(2);
   endtask

   task automatic apply_cfg(input int code, input bit both);
      if (vclk_in) begin
         vclk_in = 1'b0; step(6);
      end
      prescale_code = 2'(code);
      edge_both = both;
      step(2);
      do_soft_reset();
   endtask

   initial begin
      #(LIMIT * 4);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
   end

   initial begin
      int base, n;
      step(3);
      rst_n = 1'b1;
      step(2);
      // R9: reset state and no output before the first soft reset
      @(negedge clk);
      check(int'(dot_en), 0, "R9 dot_en after reset");
      check(int'(active), 0, "R9/R8 active after reset");
      step(1);
      base = pulses;
      events(40, 1'b0);
      check(pulses - base, 0, "R9 no pulse before soft reset");

      // R1/R2/R3: sweep every prescale and edge mode pair
      for (int c = 0; c < 4; c++) begin
         for (int b = 0; b < 2; b++) begin
            n = 8 * (c + 1);
            apply_cfg(c, b[0]);
            base = pulses;
            events(n - 1, b[0]);
            check(pulses - base, 0, "R3 silent before first period");
            events(1, b[0]);
            check(pulses - base, 1, "R3 pulse on last edge of first period");
            events(2 * n, b[0]);
            check(pulses - base, 3, b ? "R2 pulse count" : "R1 pulse count");
            check(t_last - t_prev, b ? n * H : n * 2 * H,
                  b ? "R2 spacing both edges" : "R1 spacing rising edges");
         end
      end

      // R5: settings changed without soft reset are not applied
      apply_cfg(1, 1'b0);
      prescale_code = 2'd3; edge_both = 1'b1;
      step(3);
      base = pulses;
      events(15, 1'b0);
      check(pulses - base, 0, "R5 old ratio kept, before period");
      events(1, 1'b0);
      check(pulses - base, 1, "R5 old ratio kept, pulse at 16");
      do_soft_reset();
      base = pulses;
      events(31, 1'b1);
      check(pulses - base, 0, "R5 new ratio after soft reset, before period");
      events(1, 1'b1);
      check(pulses - base, 1, "R5 new ratio after soft reset, pulse at 32");

      // R6: soft reset in mid-period discards earlier edges
      apply_cfg(2, 1'b0);
      events(5, 1'b0);
      do_soft_reset();
      base = pulses;
      events(23, 1'b0);
      check(pulses - base, 0, "R6 stale edges discarded");
      events(1, 1'b0);
      check(pulses - base, 1, "R6 pulse after full period");

      // R7/R8: bypass passes through and freezes counters
      apply_cfg(0, 1'b1);
      events(3, 1'b1);
      src_pll = 1'b0;
      step(1);
      check(int'(active), 0, "R8 active low in bypass");
      bypass_en = 1'b1;
      @(negedge clk);
      check(int'(dot_en), 1, "R7 bypass high passes");
      step(1);
      bypass_en = 1'b0;
      @(negedge clk);
      check(int'(dot_en), 0, "R7 bypass low passes");
      step(1);
      base = pulses;
      events(20, 1'b1);
      check(pulses - base, 0, "R7 no pulse during bypass");
      src_pll = 1'b1;
      step(2);
      check(int'(active), 1, "R8 active with divider selected");
      base = pulses;
      events(4, 1'b1);
      check(pulses - base, 0, "R7 held count resumes, before period");
      events(1, 1'b1);
      check(pulses - base, 1, "R7 held count resumes, pulse at 8");

      // R4: no two-cycle divider pulse across the whole run
      check(dbl, 0, "R4 single-cycle pulses");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule